// File: doc/BRIEF.md
# Four-way address strap detector

This block lives inside an I2C target and works out how a single address-select pin has been wired on the board. The pin may be tied to ground, tied to supply, or joined to one of the two bus wires (clock or data). Instead of reading a static level at reset, the block watches the pin during the first five address bits that follow a START condition. It compares the pin against each candidate source at every sample point. The resulting two-bit code gives the target two address bits from one physical pin.

All three inputs are asynchronous to the system clock and pass through a two-flop synchronizer. The block then detects the START condition, clock rising edges and data transitions. It samples the pin at each clock rise and each data transition inside the window. Data changes only while the clock is low, so these two kinds of sample points tell clock-tracking apart from data-tracking. When the fifth clock rise closes the window, the block either reports a connection and keeps it until reset, or rejects the window and waits for another START. The system clock must run at least eight times faster than the bus clock.

Top module: `strap_detect`

## Requirements
- R1: After reset, `conn_valid_o` is 0 and `conn_code_o` is 00. Each input passes through a two-stage synchronizer. A completed decision appears on the outputs three system clocks after the input sample that caused it.
- R2: A START condition opens a fresh observation window and clears all earlier evidence. A START is the synchronized data line falling while the synchronized clock line is high. This also applies to a START that arrives inside an open window.
- R3: Inside the window, the pin is sampled at every clock rising edge and at every data transition. The window closes on the fifth clock rising edge, and the outputs do not become valid before that edge.
- R4: If the pin reads 0 at every sample, the result is code 00 (ground). This case has the highest priority.
- R5: If the pin reads 1 at every sample and the ground case does not apply, the result is code 01 (supply).
- R6: If the pin equals the clock line at every sample, but does not equal the data line at every sample, the result is code 10 (clock-connected).
- R7: If the pin equals the data line at every sample, but does not equal the clock line at every sample, the result is code 11 (data-connected).
- R8: If the samples fit none of the four patterns, `conn_valid_o` stays 0 and the block waits for the next START, where it tries again from scratch.
- R9: Once `conn_valid_o` is 1, it stays 1 and `conn_code_o` holds its value until reset. Later bus traffic, STARTs and pin changes have no effect.
- R10: Clock pulses and data movement without a START never open a window and never set `conn_valid_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| strap_i | input | 1 | Address strap pin, asynchronous |
| conn_code_o | output | 2 | Connection code: 00 ground, 01 supply, 10 clock, 11 data |
| conn_valid_o | output | 1 | High once a connection is decided; sticky until reset |

## Verification
The in-RTL properties check on every cycle that:
- the valid flag and the code stay frozen once set;
- the window counter never passes its limit;
- every START seen before a decision leaves the block watching;
- a START is never also counted as a clock rise;
- the valid flag only rises on the cycle after a window closes.

Which wiring gets reported, the priority of ground over the other patterns, the rejection of inconsistent samples followed by a retry, and the restart on a repeated START can only be shown by the bench's bus scenarios. The bench drives the strap pin in each wiring mode and compares against a reference model that runs in lock-step on every clock.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Connection codes; the numeric values are the address bits handed on.
  typedef enum logic [1:0] {
    CONN_GND = 2'b00,
    CONN_VCC = 2'b01,
    CONN_SCL = 2'b10,
    CONN_SDA = 2'b11
  } conn_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WATCH = 2'b01,
    ST_DONE  = 2'b10
  } det_state_e;

  // One evidence flag per candidate wiring; cleared by the first contradiction.
  typedef struct packed {
    logic low_ok;
    logic high_ok;
    logic scl_ok;
    logic sda_ok;
  } fit_t;

  localparam fit_t FIT_ALL = '{low_ok: 1'b1, high_ok: 1'b1, scl_ok: 1'b1, sda_ok: 1'b1};

  function automatic fit_t fit_update(input fit_t f, input logic pin,
                                      input logic scl, input logic sda);
    fit_t n;
    n.low_ok  = f.low_ok  & ~pin;
    n.high_ok = f.high_ok &  pin;
    n.scl_ok  = f.scl_ok  & (pin == scl);
    n.sda_ok  = f.sda_ok  & (pin == sda);
    return n;
  endfunction

  // A window is usable when a static level fits, or exactly one bus line fits.
  function automatic logic fit_decides(input fit_t f);
    return f.low_ok | f.high_ok | (f.scl_ok ^ f.sda_ok);
  endfunction

  function automatic conn_e fit_choice(input fit_t f);
    if (f.low_ok)       return CONN_GND;
    else if (f.high_ok) return CONN_VCC;
    else if (f.scl_ok)  return CONN_SCL;
    else                return CONN_SDA;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/strap_bus_events.sv
module strap_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic scl_rise,
  output logic sda_edge
);

  logic scl_q, sda_q;

  // Previous levels reset to the idle bus state so reset itself looks quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_evt = scl_q & scl & sda_q & ~sda;
  assign scl_rise  = ~scl_q & scl;
  assign sda_edge  = sda_q ^ sda;

  // R2: a START happens with the clock held high, so it can never be a clock rise
  p_start_not_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !scl_rise);

endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_pkg::*;
#(
  parameter int WINDOW_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       scl_rise,
  input  logic       sda_edge,
  input  logic       pin,
  input  logic       scl,
  input  logic       sda,
  output logic       watching,
  output logic       close_evt,
  output logic       valid,
  output logic [1:0] code
);

  localparam int CNT_W = (WINDOW_BITS > 2) ? $clog2(WINDOW_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW_BITS - 1);

  det_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  fit_t             fit_q, fit_next;
  logic             sample_evt;
  conn_e            code_q;

  assign watching   = (state_q == ST_WATCH);
  assign sample_evt = watching && !start_evt && (scl_rise || sda_edge);
  assign fit_next   = fit_update(fit_q, pin, scl, sda);
  assign close_evt  = sample_evt && scl_rise && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fit_q   <= FIT_ALL;
      valid   <= 1'b0;
      code_q  <= CONN_GND;
    end else begin
      case (state_q)
        ST_IDLE, ST_WATCH: begin
          if (start_evt) begin
            state_q <= ST_WATCH;
            cnt_q   <= '0;
            fit_q   <= FIT_ALL;
          end else if (sample_evt) begin
            fit_q <= fit_next;
            if (close_evt) begin
              if (fit_decides(fit_next)) begin
                state_q <= ST_DONE;
                valid   <= 1'b1;
                code_q  <= fit_choice(fit_next);
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (scl_rise) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          state_q <= ST_DONE;
        end
      endcase
    end
  end

  assign code = code_q;

  // R9: decision is sticky
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  // R9: code is frozen once reported
  p_code_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(code));
  // R3: the window counter never passes the last bit index
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);
  // R2: a START before any decision leaves the block watching
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !valid) |=> watching);
  // R3: valid only rises right after a window closes
  p_valid_after_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid ##1 valid) |-> $past(close_evt));

endmodule

// File: rtl/strap_detect.sv
module strap_detect
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       strap_i,
  output logic [1:0] conn_code_o,
  output logic       conn_valid_o
);

  localparam int          N_IN    = 3;
  localparam logic [2:0]  IN_IDLE = 3'b110; // {scl, sda, pin}

  logic [N_IN-1:0] raw_in, sync_in;
  logic            scl_s, sda_s, pin_s;
  logic            start_evt, scl_rise, sda_edge;
  logic            watching, close_evt;

  assign raw_in = {scl_i, sda_i, strap_i};

  strap_sync #(
    .WIDTH  (N_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_in)
  );

  assign {scl_s, sda_s, pin_s} = sync_in;

  strap_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_s),
    .sda      (sda_s),
    .start_evt(start_evt),
    .scl_rise (scl_rise),
    .sda_edge (sda_edge)
  );

  strap_classifier #(
    .WINDOW_BITS(WINDOW_BITS)
  ) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .scl_rise (scl_rise),
    .sda_edge (sda_edge),
    .pin      (pin_s),
    .scl      (scl_s),
    .sda      (sda_s),
    .watching (watching),
    .close_evt(close_evt),
    .valid    (conn_valid_o),
    .code     (conn_code_o)
  );

  // R10: no window means no decision can appear
  p_no_valid_without_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!watching && !conn_valid_o) |=> !conn_valid_o);

endmodule

// File: tb/strap_detect_tb.sv
module strap_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_d = 1'b1;
  logic       sda_d = 1'b1;
  logic       pin_d;
  int         mode = 1; // 0 gnd, 1 vcc, 2 scl, 3 sda, 4 inverted scl
  logic [1:0] conn_code_o;
  logic       conn_valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz

  always_comb begin
    case (mode)
      0:       pin_d = 1'b0;
      1:       pin_d = 1'b1;
      2:       pin_d = scl_d;
      3:       pin_d = sda_d;
      default: pin_d = ~scl_d;
    endcase
  end

  strap_detect u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_d),
    .sda_i       (sda_d),
    .strap_i     (pin_d),
    .conn_code_o (conn_code_o),
    .conn_valid_o(conn_valid_o)
  );

  // ---------------- reference model ----------------
  // history entries {scl, sda, pin}; h[0] newest sample
  logic [2:0] h [4];
  bit m_watch, m_valid;
  int m_cnt;
  bit f_low, f_high, f_scl, f_sda;
  logic [1:0] m_code;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) h[i] = 3'b110;
    m_watch = 0; m_valid = 0; m_cnt = 0; m_code = 2'b00;
    f_low = 1; f_high = 1; f_scl = 1; f_sda = 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit c_scl, c_sda, c_pin, o_scl, o_sda, st, rise, tog;
      for (int i = 3; i > 0; i--) h[i] = h[i-1];
      h[0] = {scl_d, sda_d, pin_d};
      {c_scl, c_sda, c_pin} = h[2];
      {o_scl, o_sda}        = h[3][2:1];
      st   = o_scl && c_scl && o_sda && !c_sda;
      rise = !o_scl && c_scl;
      tog  = o_sda != c_sda;
      if (!m_valid) begin
        if (st) begin
          m_watch = 1; m_cnt = 0;
          f_low = 1; f_high = 1; f_scl = 1; f_sda = 1;
        end else if (m_watch && (rise || tog)) begin
          if (c_pin) f_low = 0;
          if (!c_pin) f_high = 0;
          if (c_pin != c_scl) f_scl = 0;
          if (c_pin != c_sda) f_sda = 0;
          if (rise) m_cnt++;
          if (m_cnt == 5) begin
            m_watch = 0;
            if (f_low)                   begin m_valid = 1; m_code = 2'b00; end
            else if (f_high)             begin m_valid = 1; m_code = 2'b01; end
            else if (f_scl && !f_sda)    begin m_valid = 1; m_code = 2'b10; end
            else if (f_sda && !f_scl)    begin m_valid = 1; m_code = 2'b11; end
          end
        end
      end
    end
  end

  // R1 R3: lock-step comparison on every clock
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (conn_valid_o !== m_valid || (m_valid && conn_code_o !== m_code)) begin
        bad++;
        $display("FAIL R1 model compare: valid/code actual=%b/%b expected=%b/%b",
                 conn_valid_o, conn_code_o, m_valid, m_code);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input bit v, input logic [1:0] c);
    check(conn_valid_o === v, {req, " valid"}, conn_valid_o, v);
    if (v) check(conn_code_o === c, {req, " code"}, conn_code_o, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scl_d = 1'b1; sda_d = 1'b1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic bus_start();
    scl_d = 1'b0; wait_clk(4);
    sda_d = 1'b1; wait_clk(4);
    scl_d = 1'b1; wait_clk(8);
    sda_d = 1'b0; wait_clk(8);
  endtask

  task automatic bus_bit(input bit b);
    scl_d = 1'b0; wait_clk(4);
    sda_d = b;    wait_clk(4);
    scl_d = 1'b1; wait_clk(8);
  endtask

  task automatic bus_bits(input logic [4:0] v, input int n);
    for (int i = 4; i > 4 - n; i--) bus_bit(v[i]);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    do_reset();
    check_out("R1 reset state", 0, 2'b00);
    check(conn_code_o === 2'b00, "R1 reset code", conn_code_o, 0);

    // R10: clock pulses and data moves, no START
    mode = 1;
    for (int i = 0; i < 6; i++) begin
      scl_d = 1'b0; wait_clk(4);
      sda_d = i[0]; wait_clk(4);
      sda_d = 1'b1; wait_clk(2);
      scl_d = 1'b1; wait_clk(8);
    end
    check_out("R10 no start", 0, 2'b00);

    // R4 ground, then R9 freeze
    mode = 0;
    bus_start();
    bus_bits(5'b10100, 5);
    wait_clk(4);
    check_out("R4 ground", 1, 2'b00);
    mode = 1;
    bus_start();
    bus_bits(5'b01101, 5);
    wait_clk(4);
    check_out("R9 frozen after decision", 1, 2'b00);

    // R5 supply and R3 window length
    do_reset();
    mode = 1;
    bus_start();
    bus_bits(5'b01110, 4);
    wait_clk(4);
    check_out("R3 four bits not enough", 0, 2'b00);
    bus_bit(1'b0);
    wait_clk(4);
    check_out("R5 supply", 1, 2'b01);

    // R6 clock-connected
    do_reset();
    mode = 2;
    bus_start();
    bus_bits(5'b10110, 5);
    wait_clk(4);
    check_out("R6 clock", 1, 2'b10);

    // R7 data-connected
    do_reset();
    mode = 3;
    bus_start();
    bus_bits(5'b10011, 5);
    wait_clk(4);
    check_out("R7 data", 1, 2'b11);

    // R8 no fit, then retry at next START
    do_reset();
    mode = 4;
    bus_start();
    bus_bits(5'b10101, 5);
    wait_clk(4);
    check_out("R8 rejected window", 0, 2'b00);
    mode = 1;
    bus_bits(5'b11000, 3);
    check_out("R8 no decision without start", 0, 2'b00);
    bus_start();
    bus_bits(5'b01101, 5);
    wait_clk(4);
    check_out("R8 retry decides", 1, 2'b01);

    // R2 repeated START restarts the window
    do_reset();
    mode = 2;
    bus_start();
    bus_bits(5'b10100, 3);
    mode = 1;
    bus_start();
    bus_bits(5'b00110, 4);
    wait_clk(4);
    check_out("R2 count restarted", 0, 2'b00);
    bus_bit(1'b0);
    wait_clk(4);
    check_out("R2 repeated start", 1, 2'b01);

    wait_clk(10);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule